// File: doc/BRIEF.md
# Byte-Addressed SPI Register Port

This block lets an SPI master read and write a small bank of byte-wide registers. The registers themselves live elsewhere. Every transaction starts with one command byte. Bit 7 of that byte picks the direction, and bits 6..0 give the starting register offset. Any number of data bytes may follow, each sent MSB first. After every data byte the offset steps forward by one. Only the low seven bits count, so the offset wraps inside its half of the address space and the direction is kept.

The SPI pins are oversampled by a fast system clock through two-flop synchronisers. The clock phase is fixed at the second-edge variant (CPHA = 1), so modes 1 and 3 are served. The polarity is captured from the serial clock's level at the moment chip select falls. The register side sees an offset, a write strobe with data, a read strobe with combinational read data, and a separate strobe. That separate strobe marks reads of result registers, so conversion-ready logic can release its flag.

The transfer state machine has four states:
- `ST_IDLE` waits for chip select.
- `ST_ADDR` collects the command byte.
- `ST_WR` commits a register write on each completed data byte.
- `ST_RD` loads and shifts out one register per byte.

It has these transitions:
- chip-select fall: `ST_IDLE`→`ST_ADDR`
- command byte complete with bit 7 = 1: `ST_ADDR`→`ST_WR`
- command byte complete with bit 7 = 0: `ST_ADDR`→`ST_RD`
- chip-select rise: any state → `ST_IDLE`

Top module: `spi_regbank_slave`

## Requirements
- R1: A command byte with bit 7 = 1 starts a write. Each completed data byte raises `rf_wr_en` for one cycle, with `rf_addr` = offset[2:0] and `rf_wr_data` = the byte. A command byte with bit 7 = 0 starts a read.
- R2: The polarity is taken from the level of `spi_sclk` when `spi_csn` falls. If the clock idles high, MOSI is sampled on rising edges and MISO changes on falling edges. If it idles low, the edges are swapped. Both polarities transfer the same data.
- R3: After each data byte the offset increments in bits 6..0 only. A write burst wraps from FFh to 80h, and a read burst wraps from 7Fh to 00h.
- R4: Offsets 08h..7Fh are unimplemented. Reading one shifts out FFh and raises no `rf_rd_en`. Writing one raises no `rf_wr_en`.
- R5: A write to a read-only offset raises no `rf_wr_en`. With the default mask the read-only offsets are 1, 2 and 7. The burst still advances past that offset.
- R6: `spi_miso_oe` is low in three cases: throughout the command byte, in any write transaction, and whenever `spi_csn` is high. In a read it is high from the first shift edge of the first data byte.
- R7: `rf_result_rd` pulses once for each data byte read from a result offset (default offsets 1 and 2), and only together with `rf_rd_en`.
- R8: If `spi_csn` rises partway through a byte, those bits are dropped and no write is committed.
- R9: `rf_rd_en` pulses exactly once per data byte read from an implemented offset, and never in the same cycle as `rf_wr_en`.
- R10: After reset, `spi_miso_oe`, `rf_wr_en`, `rf_rd_en` and `rf_result_rd` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the MISO driver |
| rf_addr | output | 3 | Register offset for read or write |
| rf_wr_en | output | 1 | One-cycle write strobe |
| rf_wr_data | output | 8 | Write data |
| rf_rd_en | output | 1 | One-cycle read strobe |
| rf_rd_data | input | 8 | Read data, valid in the cycle of `rf_rd_en` |
| rf_result_rd | output | 1 | Pulses when a result register is read |

## Verification
The hardest case to reach from the ports is the wrap of a write burst from FFh to 80h. It needs a burst that starts in the unimplemented range and lands on a real register two bytes later. The stimulus starts a burst at FEh and checks that the only committed write is the third byte, landing on offset 0.

The polarity is switched between mode 1 and mode 3 from one transaction to the next, while chip select is high. This makes the detection run fresh on every chip-select fall.

A write burst is cut after four bits to exercise the dropped partial byte.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_WR   = 2'd2,
        ST_RD   = 2'd3
    } xfer_state_e;

    // Offset step: bit 7 (direction) is kept, bits 6..0 wrap.
    function automatic logic [7:0] step_addr(input logic [7:0] a);
        return {a[7], a[6:0] + 7'd1};
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sclk,
    input  logic spi_csn,
    input  logic spi_mosi,
    output logic cs_start,
    output logic cs_end,
    output logic sample_ev,
    output logic shift_ev,
    output logic mosi_bit
);

    logic [SYNC_STAGES-1:0] sclk_ff;
    logic [SYNC_STAGES-1:0] csn_ff;
    logic [SYNC_STAGES-1:0] mosi_ff;
    logic sclk_s, csn_s;
    logic sclk_q, csn_q;
    logic cpol_q;
    logic active, rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_ff <= '0;
            csn_ff  <= '1;
            mosi_ff <= '0;
            sclk_q  <= 1'b0;
            csn_q   <= 1'b1;
            cpol_q  <= 1'b0;
        end else begin
            sclk_ff <= {sclk_ff[SYNC_STAGES-2:0], spi_sclk};
            csn_ff  <= {csn_ff[SYNC_STAGES-2:0], spi_csn};
            mosi_ff <= {mosi_ff[SYNC_STAGES-2:0], spi_mosi};
            sclk_q  <= sclk_s;
            csn_q   <= csn_s;
            if (cs_start) begin
                cpol_q <= sclk_s;
            end
        end
    end

    always_comb begin
        sclk_s    = sclk_ff[SYNC_STAGES-1];
        csn_s     = csn_ff[SYNC_STAGES-1];
        mosi_bit  = mosi_ff[SYNC_STAGES-1];
        cs_start  = csn_q & ~csn_s;
        cs_end    = csn_s & ~csn_q;
        active    = ~csn_s & ~csn_q;
        rise      = sclk_s & ~sclk_q;
        fall      = ~sclk_s & sclk_q;
        sample_ev = active & (cpol_q ? rise : fall);
        shift_ev  = active & (cpol_q ? fall : rise);
    end

    p_one_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_ev && shift_ev));

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |-> !(sample_ev || shift_ev));

endmodule

// File: rtl/spi_xfer_fsm.sv
module spi_xfer_fsm
    import spi_regbank_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter logic [NUM_REGS-1:0] RO_MASK  = 8'h86,
    parameter logic [NUM_REGS-1:0] RES_MASK = 8'h06,
    localparam int ADDR_W = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              sample_ev,
    input  logic              shift_ev,
    input  logic              mosi_bit,
    input  logic [7:0]        rf_rd_data,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_wr_en,
    output logic [7:0]        rf_wr_data,
    output logic              rf_rd_en,
    output logic              rf_result_rd,
    output logic              miso_bit,
    output logic              tx_valid
);

    xfer_state_e state_q, state_d;
    logic [2:0]  bit_cnt_q;
    logic [6:0]  rx_q;
    logic [7:0]  addr_q;
    logic [7:0]  tx_q;
    logic        tx_valid_q;
    logic [7:0]  rx_byte;
    logic        byte_done;
    logic        addr_ok;
    logic        load_ev;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        rx_byte   = {rx_q, mosi_bit};
        byte_done = sample_ev && (bit_cnt_q == 3'd7);
        idx       = addr_q[ADDR_W-1:0];
        addr_ok   = (addr_q[6:0] < 7'(NUM_REGS));
        load_ev   = shift_ev && (state_q == ST_RD) && (bit_cnt_q == 3'd0);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_start) state_d = ST_ADDR;
            ST_ADDR: begin
                if (cs_end) begin
                    state_d = ST_IDLE;
                end else if (byte_done) begin
                    state_d = rx_byte[7] ? ST_WR : ST_RD;
                end
            end
            ST_WR:   if (cs_end) state_d = ST_IDLE;
            ST_RD:   if (cs_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            rx_q       <= '0;
            addr_q     <= '0;
            tx_q       <= 8'hFF;
            tx_valid_q <= 1'b0;
        end else begin
            if (cs_start || cs_end) begin
                bit_cnt_q <= '0;
            end else if (sample_ev) begin
                bit_cnt_q <= bit_cnt_q + 3'd1;
            end
            if (sample_ev) begin
                rx_q <= rx_byte[6:0];
            end
            if (byte_done) begin
                if (state_q == ST_ADDR) begin
                    addr_q <= rx_byte;
                end else if (state_q == ST_WR || state_q == ST_RD) begin
                    addr_q <= step_addr(addr_q);
                end
            end
            if (load_ev) begin
                tx_q <= addr_ok ? rf_rd_data : 8'hFF;
            end else if (shift_ev && state_q == ST_RD) begin
                tx_q <= {tx_q[6:0], 1'b1};
            end
            if (cs_start || cs_end) begin
                tx_valid_q <= 1'b0;
            end else if (load_ev) begin
                tx_valid_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        rf_addr      = idx;
        rf_wr_data   = rx_byte;
        rf_wr_en     = (state_q == ST_WR) && byte_done && addr_ok && !RO_MASK[idx];
        rf_rd_en     = load_ev && addr_ok;
        rf_result_rd = load_ev && addr_ok && RES_MASK[idx];
        miso_bit     = tx_q[7];
        tx_valid     = tx_valid_q;
    end

    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && rf_rd_en));

    p_oe_read_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_q |-> (state_q == ST_RD));

    p_wrap_keeps_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && (state_q == ST_WR || state_q == ST_RD))
        |=> (addr_q[7] == $past(addr_q[7])));

    p_result_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rf_result_rd |-> rf_rd_en);

    p_write_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (addr_q[6:0] < 7'(NUM_REGS)));

    p_write_after_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> (state_q == ST_WR && addr_q[7]));

endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_REGS-1:0] RO_MASK  = 8'h86,
    parameter logic [NUM_REGS-1:0] RES_MASK = 8'h06
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_sclk,
    input  logic                        spi_csn,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic                        spi_miso_oe,
    output logic [$clog2(NUM_REGS)-1:0] rf_addr,
    output logic                        rf_wr_en,
    output logic [7:0]                  rf_wr_data,
    output logic                        rf_rd_en,
    input  logic [7:0]                  rf_rd_data,
    output logic                        rf_result_rd
);

    logic cs_start, cs_end, sample_ev, shift_ev, mosi_bit, tx_valid;

    spi_pin_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_csn   (spi_csn),
        .spi_mosi  (spi_mosi),
        .cs_start  (cs_start),
        .cs_end    (cs_end),
        .sample_ev (sample_ev),
        .shift_ev  (shift_ev),
        .mosi_bit  (mosi_bit)
    );

    spi_xfer_fsm #(
        .NUM_REGS (NUM_REGS),
        .RO_MASK  (RO_MASK),
        .RES_MASK (RES_MASK)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_start     (cs_start),
        .cs_end       (cs_end),
        .sample_ev    (sample_ev),
        .shift_ev     (shift_ev),
        .mosi_bit     (mosi_bit),
        .rf_rd_data   (rf_rd_data),
        .rf_addr      (rf_addr),
        .rf_wr_en     (rf_wr_en),
        .rf_wr_data   (rf_wr_data),
        .rf_rd_en     (rf_rd_en),
        .rf_result_rd (rf_result_rd),
        .miso_bit     (spi_miso),
        .tx_valid     (tx_valid)
    );

    // Raw chip select gates the enable so the pin releases at once.
    assign spi_miso_oe = tx_valid & ~spi_csn;

    p_oe_off_cs_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> !spi_miso_oe);

endmodule

// File: tb/spi_regbank_slave_tb_top.sv
`timescale 1ns/1ps
module spi_regbank_slave_tb_top;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk, spi_csn, spi_mosi;
    logic       spi_miso, spi_miso_oe;
    logic [2:0] rf_addr;
    logic       rf_wr_en, rf_rd_en, rf_result_rd;
    logic [7:0] rf_wr_data, rf_rd_data;

    logic [7:0] model_regs [8];
    logic [7:0] tx_bytes [$];
    logic [7:0] rx_bytes [$];
    int         exp_wa [$];
    logic [7:0] exp_wd [$];
    int checks = 0;
    int failures = 0;
    int rd_pulses = 0;
    int res_pulses = 0;

    always #2.5 clk = ~clk;

    assign rf_rd_data = model_regs[rf_addr];

    spi_regbank_slave dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sclk     (spi_sclk),
        .spi_csn      (spi_csn),
        .spi_mosi     (spi_mosi),
        .spi_miso     (spi_miso),
        .spi_miso_oe  (spi_miso_oe),
        .rf_addr      (rf_addr),
        .rf_wr_en     (rf_wr_en),
        .rf_wr_data   (rf_wr_data),
        .rf_rd_en     (rf_rd_en),
        .rf_rd_data   (rf_rd_data),
        .rf_result_rd (rf_result_rd)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock reference monitor
    always @(negedge clk) begin
        int a;
        logic [7:0] d;
        if (rst_n) begin
            if (spi_csn) check(!spi_miso_oe, "R6", "oe with cs high", int'(spi_miso_oe), 0);
            if (rf_wr_en && rf_rd_en) check(1'b0, "R9", "both strobes", 1, 0);
            if (rf_result_rd && !rf_rd_en) check(1'b0, "R7", "result strobe alone", 1, 0);
            if (rf_rd_en) rd_pulses++;
            if (rf_result_rd) res_pulses++;
            if (rf_wr_en) begin
                if (exp_wa.size() == 0) begin
                    check(1'b0, "R5 or R8", "unexpected write addr", int'(rf_addr), -1);
                end else begin
                    a = exp_wa.pop_front();
                    d = exp_wd.pop_front();
                    check(int'(rf_addr) == a, "R1", "write addr", int'(rf_addr), a);
                    check(rf_wr_data == d, "R1", "write data", int'(rf_wr_data), int'(d));
                end
                model_regs[rf_addr] = rf_wr_data;
            end
        end
    end

    task automatic spi_xfer(input bit cpol, input int last_bits);
        int nb;
        bit is_rd;
        rx_bytes.delete();
        rd_pulses = 0;
        res_pulses = 0;
        nb = tx_bytes.size();
        is_rd = !tx_bytes[0][7];
        @(negedge clk);
        spi_sclk = cpol;
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nb; b++) begin
            logic [7:0] got;
            int nbits;
            int oe_bad;
            nbits = (b == nb - 1) ? last_bits : 8;
            got = 8'h00;
            oe_bad = 0;
            for (int i = 0; i < nbits; i++) begin
                spi_sclk = ~cpol;
                spi_mosi = tx_bytes[b][7-i];
                repeat (HALF) @(negedge clk);
                got = {got[6:0], spi_miso};
                if (spi_miso_oe !== (is_rd && b > 0)) oe_bad++;
                spi_sclk = cpol;
                repeat (HALF) @(negedge clk);
            end
            check(oe_bad == 0, "R6", "oe wrong during byte", oe_bad, 0);
            rx_bytes.push_back(got);
        end
        repeat (HALF) @(negedge clk);
        spi_csn = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    initial begin
        spi_csn = 1'b1;
        spi_sclk = 1'b1;
        spi_mosi = 1'b0;
        for (int i = 0; i < 8; i++) model_regs[i] = 8'h10 + 8'(i);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(spi_miso_oe == 1'b0, "R10", "oe after reset", int'(spi_miso_oe), 0);
        check(!rf_wr_en && !rf_rd_en && !rf_result_rd, "R10", "strobes after reset",
              int'({rf_wr_en, rf_rd_en, rf_result_rd}), 0);

        // R1 R2: single write, clock idles high
        tx_bytes = '{8'h80, 8'h5A};
        exp_wa.push_back(0); exp_wd.push_back(8'h5A);
        spi_xfer(1'b1, 8);
        check(exp_wa.size() == 0, "R1", "writes pending", exp_wa.size(), 0);

        // R2 R3 R7 R9: full read burst, clock idles low
        tx_bytes = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        spi_xfer(1'b0, 8);
        for (int i = 0; i < 8; i++)
            check(rx_bytes[i+1] == model_regs[i], "R2", "burst read byte",
                  int'(rx_bytes[i+1]), int'(model_regs[i]));
        check(rx_bytes[1] == 8'h5A, "R1", "readback of write", int'(rx_bytes[1]), 8'h5A);
        check(rd_pulses == 8, "R9", "read strobes", rd_pulses, 8);
        check(res_pulses == 2, "R7", "result strobes", res_pulses, 2);

        // R3 R4: read wraps 7Fh -> 00h, clock idles high
        tx_bytes = '{8'h7E, 8'h00, 8'h00, 8'h00, 8'h00};
        spi_xfer(1'b1, 8);
        check(rx_bytes[1] == 8'hFF, "R4", "invalid read 7E", int'(rx_bytes[1]), 8'hFF);
        check(rx_bytes[2] == 8'hFF, "R4", "invalid read 7F", int'(rx_bytes[2]), 8'hFF);
        check(rx_bytes[3] == model_regs[0], "R3", "wrap to 00", int'(rx_bytes[3]), int'(model_regs[0]));
        check(rx_bytes[4] == model_regs[1], "R3", "wrap to 01", int'(rx_bytes[4]), int'(model_regs[1]));
        check(rd_pulses == 2, "R4", "no strobe for invalid reads", rd_pulses, 2);
        check(res_pulses == 1, "R7", "result strobe after wrap", res_pulses, 1);

        // R3 R4: write wraps FFh -> 80h, clock idles low
        tx_bytes = '{8'hFE, 8'hA1, 8'hA2, 8'hC3};
        exp_wa.push_back(0); exp_wd.push_back(8'hC3);
        spi_xfer(1'b0, 8);
        check(exp_wa.size() == 0, "R3", "wrap write committed", exp_wa.size(), 0);

        // R5: read-only offsets skipped, burst still advances
        tx_bytes = '{8'h81, 8'h11, 8'h22, 8'h33, 8'h44};
        exp_wa.push_back(3); exp_wd.push_back(8'h33);
        exp_wa.push_back(4); exp_wd.push_back(8'h44);
        spi_xfer(1'b1, 8);
        check(exp_wa.size() == 0, "R5", "writes after read-only", exp_wa.size(), 0);
        tx_bytes = '{8'h87, 8'hEE};
        spi_xfer(1'b0, 8);
        tx_bytes = '{8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        spi_xfer(1'b1, 8);
        check(rx_bytes[1] == 8'h11, "R5", "offset 1 kept", int'(rx_bytes[1]), 8'h11);
        check(rx_bytes[2] == 8'h12, "R5", "offset 2 kept", int'(rx_bytes[2]), 8'h12);
        check(rx_bytes[3] == 8'h33, "R5", "offset 3 written", int'(rx_bytes[3]), 8'h33);
        check(rx_bytes[7] == 8'h17, "R5", "offset 7 kept", int'(rx_bytes[7]), 8'h17);

        // R8: partial byte dropped
        tx_bytes = '{8'h85, 8'h9C};
        spi_xfer(1'b0, 4);
        tx_bytes = '{8'h05, 8'h00};
        spi_xfer(1'b0, 8);
        check(rx_bytes[1] == 8'h15, "R8", "partial byte not written", int'(rx_bytes[1]), 8'h15);
        check(exp_wa.size() == 0, "R8", "no stray writes pending", exp_wa.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R10 watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule